// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Writes

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks. Each bank holds four ports of eight pins. Each port has five registers:

- a mode register that selects GPIO use,
- a drive-enable register,
- an output-level register,
- a read-only register that returns the sampled pin levels,
- an interrupt-enable register that holds state only.

Software reaches the registers over a simple single-cycle bus. A write is taken on the clock edge while `we` is high. Read data is combinational from `addr`.

Software often needs to change one pin without disturbing its neighbours. For that, the mode, drive-enable and output-level registers each have a second address. At that second address the upper byte of the write data selects which bits of the lower byte are taken. Software can therefore set or clear single pins without reading the register first.

A pin is driven only when its mode bit and its drive-enable bit are both set. Every other pin is left undriven.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, and while `rst_n` is low, every register reads zero and both `pin_oe` and `pin_out` are all zero.
- R2: Pin number n = bank*32 + port*8 + bit. That pin sits at bit n of `pin_in`, `pin_out` and `pin_oe`, and at bit `bit` of its port's registers. A port's plain register address is bank*BANK_STRIDE + port*4 plus a type offset: mode 0x00, drive enable 0x10, output level 0x20, input 0x30, interrupt enable 0x50.
- R3: A plain write replaces all eight bits of the register with `wdata[7:0]` and ignores `wdata[31:8]`. A read returns the register in `rdata[7:0]`, and `rdata[31:8]` is always zero.
- R4: The masked addresses for mode, drive enable and output level are the plain address + UPPER_OFFSET. On a write there, only bit i with `wdata[8+i]` = 1 takes `wdata[i]`; the other bits keep their value. A read there returns the register contents.
- R5: The interrupt-enable registers are writable and read back the last value written. They have no masked address.
- R6: `pin_oe[n]` is the mode bit AND the drive-enable bit of pin n. `pin_out[n]` equals the output-level bit when `pin_oe[n]` is 1, and 0 otherwise.
- R7: The input register returns `pin_in` through two flops. A level applied before clock edge k reads back after edge k+1. Writes to the input register have no effect.
- R8: An address that matches no register reads zero and is ignored on write. This covers unaligned addresses, unused type offsets, banks at or above BANK_COUNT, and the masked addresses of the input and interrupt-enable registers.
- R9: `pin_oe` and `pin_out` change only on a clock edge at which `we` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data; upper byte is the bit mask at masked addresses |
| we | input | 1 | Write strobe, taken on the rising clock edge |
| rdata | output | 32 | Combinational read data for `addr` |
| pin_in | input | BANK_COUNT*32 | Asynchronous pin levels |
| pin_out | output | BANK_COUNT*32 | Level driven on each pin |
| pin_oe | output | BANK_COUNT*32 | Per-pin drive enable |

## Verification
The bench builds the block with 7 banks, a bank stride of 0x80 and a masked-address offset of 0x800. With these values every masked address lies above the whole plain map. The address 0x380, which would be the first register of an eighth bank, is therefore a real unmatched address, and so is the masked image of that bank at 0xB80. A bank in the middle of the map (bank 2, port 3) and the last port of bank 6 check the bank/port/bit arithmetic away from zero. The input port of bank 0 is read on consecutive cycles to pin down the two-flop latency.

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl #(
  parameter int BANK_COUNT   = 8,
  parameter int BANK_STRIDE  = 'h100,
  parameter int UPPER_OFFSET = 'h80,
  parameter int ADDR_W       = 12,
  localparam int NPINS       = BANK_COUNT * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  output logic [31:0]       rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  localparam int NPORTS = BANK_COUNT * 4;
  localparam int PW     = $clog2(NPORTS);
  localparam logic [2:0] K_MODE = 3'd0;
  localparam logic [2:0] K_DRV  = 3'd1;
  localparam logic [2:0] K_LVL  = 3'd2;
  localparam logic [2:0] K_IN   = 3'd3;
  localparam logic [2:0] K_IEN  = 3'd5;

  logic [NPINS-1:0] mode_q, drv_q, lvl_q, ien_q, meta_q, sync_q;
  logic [31:0]      a32, pb, pr, am, mb, mr;
  logic             p_hit, m_hit, hit, masked;
  logic [2:0]       kind;
  logic [PW-1:0]    pidx;
  logic [7:0]       cur, wmask, nxt;

  always_comb begin
    a32   = 32'(addr);
    pb    = a32 / $unsigned(BANK_STRIDE);
    pr    = a32 % $unsigned(BANK_STRIDE);
    am    = a32 - $unsigned(UPPER_OFFSET);
    mb    = am / $unsigned(BANK_STRIDE);
    mr    = am % $unsigned(BANK_STRIDE);
    p_hit = (pb < $unsigned(BANK_COUNT)) && (pr[1:0] == 2'b00) &&
            (pr < 32'h60) && (pr[6:4] != 3'd4);
    m_hit = (a32 >= $unsigned(UPPER_OFFSET)) && (mb < $unsigned(BANK_COUNT)) &&
            (mr[1:0] == 2'b00) && (mr < 32'h30);
    hit    = p_hit || m_hit;
    masked = !p_hit && m_hit;
    kind   = p_hit ? pr[6:4] : (m_hit ? mr[6:4] : 3'd7);
    pidx   = p_hit ? PW'({pb[29:0], pr[3:2]}) : PW'({mb[29:0], mr[3:2]});
  end

  always_comb begin
    cur = 8'h00;
    if (hit) begin
      case (kind)
        K_MODE:  cur = mode_q[pidx*8 +: 8];
        K_DRV:   cur = drv_q[pidx*8 +: 8];
        K_LVL:   cur = lvl_q[pidx*8 +: 8];
        K_IN:    cur = sync_q[pidx*8 +: 8];
        K_IEN:   cur = ien_q[pidx*8 +: 8];
        default: cur = 8'h00;
      endcase
    end
  end

  assign rdata = {24'h0, cur};
  assign wmask = masked ? wdata[15:8] : 8'hFF;
  assign nxt   = (cur & ~wmask) | (wdata[7:0] & wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      drv_q  <= '0;
      lvl_q  <= '0;
      ien_q  <= '0;
    end else if (we && hit) begin
      case (kind)
        K_MODE:  mode_q[pidx*8 +: 8] <= nxt;
        K_DRV:   drv_q[pidx*8 +: 8]  <= nxt;
        K_LVL:   lvl_q[pidx*8 +: 8]  <= nxt;
        K_IEN:   ien_q[pidx*8 +: 8]  <= nxt;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  assign pin_oe  = mode_q & drv_q;
  assign pin_out = lvl_q & pin_oe;

endmodule

module gpio_bank_ctl_chk #(
  parameter int NP    = 256,
  parameter int UPPER = 'h80,
  parameter int AW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          we,
  input logic [31:0]   rdata,
  input logic [NP-1:0] pin_in,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] pin_oe
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R3
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:8] == 24'h0);

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(pin_oe) && $stable(pin_out)));

  // R4
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(UPPER + 'h20) && wdata[15:8] == 8'h00) |=> $stable(pin_out));

  // R7
  input_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && addr == AW'('h30)) |-> rdata[7:0] == $past(pin_in[7:0], 2));

endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(.NP(NPINS), .UPPER(UPPER_OFFSET), .AW(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_bank_ctl.sv
module sim_gpio_bank_ctl;
  localparam int CLK_P = 10;
  localparam int BC    = 7;
  localparam int ST    = 'h80;
  localparam int UP    = 'h800;
  localparam int AW    = 12;
  localparam int NP    = BC * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          we;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;

  gpio_bank_ctl #(.BANK_COUNT(BC), .BANK_STRIDE(ST), .UPPER_OFFSET(UP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #(CLK_P/2) clk = ~clk;

  int            q_kind[$];
  logic [NP-1:0] q_exp[$];
  string         q_req[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always begin
    int k;
    logic [NP-1:0] e, act;
    string r;
    @(negedge clk);
    #(CLK_P/4);
    while (q_kind.size() > 0) begin
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      r = q_req.pop_front();
      act = (k == 0) ? NP'(rdata) : ((k == 1) ? pin_oe : pin_out);
      total++;
      if (act !== e) begin
        bad++;
        $display("FAIL %s (%s) actual=%h expected=%h", r,
                 (k == 0) ? "rdata" : ((k == 1) ? "pin_oe" : "pin_out"), act, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    q_kind.push_back(0); q_exp.push_back(NP'(e)); q_req.push_back(req);
  endtask

  task automatic pins(input logic [NP-1:0] eoe, input logic [NP-1:0] eout, input string req);
    @(negedge clk);
    q_kind.push_back(1); q_exp.push_back(eoe);  q_req.push_back(req);
    q_kind.push_back(2); q_exp.push_back(eout); q_req.push_back(req);
  endtask

  task automatic set_in(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] eo, ev, vin;
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd('h000, 0, "R1 mode reset"); rd('h010, 0, "R1 drive reset");
    rd('h020, 0, "R1 level reset"); rd('h050, 0, "R1 irq reset");
    pins('0, '0, "R1 pins reset");

    wr('h000, 'hFF); wr('h010, 'h0F); wr('h020, 'hA5);
    eo = '0; ev = '0; eo[7:0] = 8'h0F; ev[7:0] = 8'h05;
    pins(eo, ev, "R6 drive gating");
    rd('h000, 'hFF, "R3 mode readback"); rd('h010, 'h0F, "R3 drive readback");
    rd('h020, 'hA5, "R3 level readback");
    wr('h020, 'hFF3C);
    rd('h020, 'h3C, "R3 upper data ignored");
    ev[7:0] = 8'h0C;
    pins(eo, ev, "R6 level follows");

    wr('h820, 'h0303); rd('h020, 'h3F, "R4 masked set"); rd('h820, 'h3F, "R4 masked readback");
    wr('h820, 'h00C0); rd('h020, 'h3F, "R4 empty mask");
    wr('h820, 'h2000); rd('h020, 'h1F, "R4 masked clear");
    ev[7:0] = 8'h0F;
    pins(eo, ev, "R4 pins after masked");

    wr('h90C, 'h8080); wr('h11C, 'h80); wr('h12C, 'hFF);
    eo[95] = 1'b1; ev[95] = 1'b1;
    pins(eo, ev, "R2 bank2 port3 bit7");
    rd('h10C, 'h80, "R2 bank2 mode");

    wr('h054, 'h5A); rd('h054, 'h5A, "R5 irq readback");
    wr('h854, 'hFF00); rd('h054, 'h5A, "R5 no masked alias"); rd('h854, 0, "R8 irq alias reads zero");

    wr('h380, 'hFF); rd('h380, 0, "R8 bank beyond count");
    wr('h040, 'hFF); rd('h040, 0, "R8 unused offset");
    wr('h060, 'hFF); rd('h060, 0, "R8 offset 0x60");
    wr('h001, 'h00); rd('h000, 'hFF, "R8 unaligned write ignored"); rd('h001, 0, "R8 unaligned read");
    wr('hB8C, 'hFFFF); rd('hB8C, 0, "R8 masked bank beyond count");
    pins(eo, ev, "R8 pins untouched");

    vin = '0; vin[7:0] = 8'hC3; vin[223:216] = 8'h5A;
    set_in(vin);
    rd('h030, 0, "R7 one-edge latency");
    rd('h030, 'hC3, "R7 synced input");
    rd('h33C, 'h5A, "R7 last port input");
    wr('h030, 'h00); rd('h030, 'hC3, "R7 input write ignored");
    rd('h830, 0, "R8 input alias reads zero");

    wr('h800, 'h0100); rd('h000, 'hFE, "R4 masked mode clear");
    eo[0] = 1'b0; ev[0] = 1'b0;
    pins(eo, ev, "R6 mode bit gates drive");

    @(negedge clk); rst_n = 1'b0;
    rd('h000, 0, "R1 mid reset mode"); rd('h12C, 0, "R1 mid reset level");
    pins('0, '0, "R1 mid reset pins");

    @(negedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule